// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Buffer

This block sits on the receive side of a multi-lane 64b/66b serial link. It stops the lanes from drifting apart in time. Each lane stores its 64-bit link-clock words in a buffer of its own, starting with the word that carries the lane's extended-multiblock boundary marker. A local multiblock counter runs from 0 to PERIOD-1, where PERIOD is E_MB*32 and E_MB is the number of multiblocks in an extended multiblock. The block samples that counter on the cycle the last lane arrives and reports the value as the arrival count.

All lanes are released together. Release happens at the counter value held in the offset input, which lets the release point sit on either side of the local multiblock tick. Release happens at once instead if the offset is out of range or the immediate-release bit is set. After release, every lane is read on every cycle, so the boundary words of all lanes come out on the same cycle. Some settings would let a buffer overflow or break the alignment. Those settings raise a sticky alignment error, and the block then releases nothing. Reset or a reinitialisation request starts a fresh alignment.

Top module: `rx_lane_deskew`

## Requirements
- R1: A lane arrives on the first cycle after clear in which its `lane_valid` and `lane_bnd` are both high, and its writes begin with that word. Each 64-bit word on `out_data` is lane l's word at bits [64*l+63 : 64*l]. The first word shown with `out_valid` high is each lane's boundary word.
- R2: `rbd_count` holds the value of `lmc_cnt` in the cycle the last lane arrives, which is a value from 0 to PERIOD-1. It reads 0 after reset and holds steady while `out_valid` is high.
- R3: Offset mode applies when `rel_offset` ≤ PERIOD-1 and `rel_now` is 0. Take the first cycle, at or after the last lane's arrival, in which `lmc_cnt` equals `rel_offset`. `out_valid` goes high two clock edges after that cycle. The offset may lie before or after the arrival count, and a lower offset waits through the counter wrap.
- R4: A `rel_offset` above PERIOD-1 means immediate release: `out_valid` goes high two clock edges after the cycle in which the last lane arrives.
- R5: When `rel_now` is 1, release is immediate whatever the value of `rel_offset`.
- R6: Once `out_valid` is high, it stays high until reset or `reinit`. Each later cycle carries each lane's next stored word, and all lanes carry the same word position.
- R7: If any lane fills all DEPTH entries of its buffer before release, `align_err` is set and `out_valid` never rises.
- R8: With more than one lane in offset mode, an offset equal to the arrival count minus 1 (modulo PERIOD; arrival count 0 pairs with offset PERIOD-1) sets `align_err` and prevents release.
- R9: `align_err` is sticky until reset or `reinit` and is never high together with `out_valid`. Reset clears `out_valid`, `align_err` and `rbd_count`.
- R10: A one-cycle `reinit` clears `out_valid` and `align_err` and restarts lane arrival, just as reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Link reinitialisation request; clears alignment state |
| lane_valid | input | LANES | Per-lane write data valid |
| lane_bnd | input | LANES | Per-lane extended-multiblock boundary marker |
| lane_data | input | LANES*DATA_W | Per-lane write data, lane l at [l*DATA_W +: DATA_W] |
| lmc_cnt | input | CNT_W | Local multiblock counter, 0 to PERIOD-1 |
| rel_offset | input | OFF_W | Programmed release counter value |
| rel_now | input | 1 | Force immediate release |
| out_data | output | LANES*DATA_W | Aligned output data |
| out_valid | output | 1 | Aligned data valid |
| rbd_count | output | CNT_W | Counter value at last-lane arrival |
| align_err | output | 1 | Sticky alignment error |

## Verification
The assertions check four things on every cycle:
- `align_err` and `out_valid` never overlap.
- Both flags stay high once set.
- The arrival count holds steady during output.
- Every offset-mode release lands exactly on a cycle whose counter equals the offset.

Only the bench scenarios can show the rest:
- that the arrival count is the right counter value;
- that the release latency is right on each side of the tick, across the counter wrap, and with out-of-range or forced immediate release;
- that the output words are aligned lane by lane;
- that the overflow and offset-minus-one settings refuse to release.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam int unsigned BLOCKS_PER_MB = 32;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_HOLD,
    ST_RUN,
    ST_FAULT
  } rel_state_t;
endpackage

// File: rtl/deskew_lane_buf.sv
module deskew_lane_buf #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int FILL_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic              wr_bnd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              arrived,
  output logic              arriving,
  output logic              full,
  output logic [DATA_W-1:0] rd_data
);
  logic              arrived_q;
  logic [ADDR_W-1:0] wptr;
  logic [FILL_W-1:0] fill;
  logic              we;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  assign arriving = wr_valid & wr_bnd & ~arrived_q;
  assign we       = wr_valid & (arrived_q | wr_bnd);
  assign full     = (fill == FILL_W'(DEPTH));
  assign arrived  = arrived_q;
  assign rd_data  = rdata_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      arrived_q <= 1'b0;
      wptr      <= '0;
      fill      <= '0;
    end else begin
      if (arriving) arrived_q <= 1'b1;
      if (we) begin
        wptr <= wptr + 1'b1;
        if (!full) fill <= fill + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= mem[rd_addr];
  end
endmodule

// File: rtl/deskew_release_ctrl.sv
module deskew_release_ctrl
  import deskew_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int PERIOD = 32,
  parameter int CNT_W  = 5,
  parameter int OFF_W  = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [LANES-1:0] arrived,
  input  logic [LANES-1:0] arriving,
  input  logic [LANES-1:0] full,
  input  logic [CNT_W-1:0] lmc_cnt,
  input  logic [OFF_W-1:0] rel_offset,
  input  logic             rel_now,
  output logic             rd_en,
  output logic             align_err,
  output logic [CNT_W-1:0] rbd_count
);
  localparam bit MULTI = (LANES > 1);

  rel_state_t       state_q, state_d;
  logic [CNT_W-1:0] count_q;
  logic             all_now, any_full, imm, hit, minus_one;
  logic [CNT_W-1:0] prev_cnt;

  assign all_now  = &(arrived | arriving);
  assign any_full = |full;
  assign imm      = rel_now | (rel_offset > OFF_W'(PERIOD - 1));
  assign hit      = imm | (OFF_W'(lmc_cnt) == rel_offset);
  assign prev_cnt = (lmc_cnt == '0) ? CNT_W'(PERIOD - 1) : lmc_cnt - 1'b1;
  assign minus_one = MULTI && !imm && (rel_offset == OFF_W'(prev_cnt));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: begin
        if (any_full)     state_d = ST_FAULT;
        else if (all_now) begin
          if (minus_one)  state_d = ST_FAULT;
          else if (hit)   state_d = ST_RUN;
          else            state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (any_full)     state_d = ST_FAULT;
        else if (hit)     state_d = ST_RUN;
      end
      ST_RUN:             state_d = ST_RUN;
      ST_FAULT:           state_d = ST_FAULT;
      default:            state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q <= ST_COLLECT;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_COLLECT && all_now) count_q <= lmc_cnt;
    end
  end

  assign rd_en     = (state_q == ST_RUN);
  assign align_err = (state_q == ST_FAULT);
  assign rbd_count = count_q;
endmodule

// File: rtl/rx_lane_deskew.sv
module rx_lane_deskew
  import deskew_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 1024,
  parameter int E_MB   = 1,
  parameter int OFF_W  = 8,
  localparam int PERIOD = E_MB * BLOCKS_PER_MB,
  localparam int CNT_W  = $clog2(PERIOD),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reinit,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES-1:0]        lane_bnd,
  input  logic [LANES*DATA_W-1:0] lane_data,
  input  logic [CNT_W-1:0]        lmc_cnt,
  input  logic [OFF_W-1:0]        rel_offset,
  input  logic                    rel_now,
  output logic [LANES*DATA_W-1:0] out_data,
  output logic                    out_valid,
  output logic [CNT_W-1:0]        rbd_count,
  output logic                    align_err
);
  logic              clr;
  logic [LANES-1:0]  arrived, arriving, full;
  logic              rd_en;
  logic [ADDR_W-1:0] rptr;
  logic              valid_q;

  assign clr = rst | reinit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deskew_lane_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_buf (
      .clk      (clk),
      .clr      (clr),
      .wr_valid (lane_valid[l]),
      .wr_bnd   (lane_bnd[l]),
      .wr_data  (lane_data[l*DATA_W +: DATA_W]),
      .rd_en    (rd_en),
      .rd_addr  (rptr),
      .arrived  (arrived[l]),
      .arriving (arriving[l]),
      .full     (full[l]),
      .rd_data  (out_data[l*DATA_W +: DATA_W])
    );
  end

  deskew_release_ctrl #(
    .LANES  (LANES),
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W),
    .OFF_W  (OFF_W)
  ) u_ctrl (
    .clk        (clk),
    .clr        (clr),
    .arrived    (arrived),
    .arriving   (arriving),
    .full       (full),
    .lmc_cnt    (lmc_cnt),
    .rel_offset (rel_offset),
    .rel_now    (rel_now),
    .rd_en      (rd_en),
    .align_err  (align_err),
    .rbd_count  (rbd_count)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      rptr    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/rx_lane_deskew_chk.sv
module rx_lane_deskew_chk #(
  parameter int CNT_W  = 5,
  parameter int OFF_W  = 8,
  parameter int PERIOD = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reinit,
  input logic [CNT_W-1:0] lmc_cnt,
  input logic [OFF_W-1:0] rel_offset,
  input logic             rel_now,
  input logic             out_valid,
  input logic [CNT_W-1:0] rbd_count,
  input logic             align_err
);
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && align_err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    align_err && !reinit |=> align_err);

  assert_valid_holds_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !reinit |=> out_valid);

  assert_count_stable_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !reinit |=> $stable(rbd_count));

  assert_offset_point_R3: assert property (@(posedge clk) disable iff (rst || reinit)
    $rose(out_valid) && !$past(rel_now, 2) && ($past(rel_offset, 2) <= OFF_W'(PERIOD - 1))
    |-> (OFF_W'($past(lmc_cnt, 2)) == $past(rel_offset, 2)));
endmodule

bind rx_lane_deskew rx_lane_deskew_chk #(
  .CNT_W  (CNT_W),
  .OFF_W  (OFF_W),
  .PERIOD (PERIOD)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reinit     (reinit),
  .lmc_cnt    (lmc_cnt),
  .rel_offset (rel_offset),
  .rel_now    (rel_now),
  .out_valid  (out_valid),
  .rbd_count  (rbd_count),
  .align_err  (align_err)
);

// File: tb/tb_rx_lane_deskew.sv
`timescale 1ns/1ps
module tb_rx_lane_deskew;
  localparam int LANES = 2, DW = 64, P = 32, NV = 8;

  logic clk = 1'b0, rst = 1'b1, reinit = 1'b0, rel_now = 1'b0;
  logic [LANES-1:0] lane_valid = '0, lane_bnd = '0;
  logic [LANES*DW-1:0] lane_data = '0, out_data;
  logic [4:0] lmc_cnt = '0, rbd_count;
  logic [7:0] rel_offset = '0;
  logic out_valid, align_err;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_lane_deskew dut (.clk(clk), .rst(rst), .reinit(reinit), .lane_valid(lane_valid),
    .lane_bnd(lane_bnd), .lane_data(lane_data), .lmc_cnt(lmc_cnt), .rel_offset(rel_offset),
    .rel_now(rel_now), .out_data(out_data), .out_valid(out_valid), .rbd_count(rbd_count),
    .align_err(align_err));

  // lane0 start, lane1 start, offset, immediate bit, expected count, expected first-valid cycle (-1: error)
  localparam int V_S0  [NV] = '{3, 3, 10, 5, 1, 3, 30, 9};
  localparam int V_S1  [NV] = '{7, 7, 10, 7, 4, 7, 32, 5};
  localparam int V_OFF [NV] = '{12, 2, 10, 40, 20, 6, 31, 0};
  localparam int V_IMM [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_CNT [NV] = '{7, 7, 10, 7, 4, 7, 0, 9};
  localparam int V_FST [NV] = '{14, 36, 12, 9, 6, -1, -1, 34};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(int off, int imm, int fst);
    if (fst < 0) return "R8";
    if (imm != 0) return "R5";
    if (off > P - 1) return "R4";
    return "R3";
  endfunction

  task automatic run_case(input int s0, input int s1, input int off, input int imm,
                          input int exp_cnt, input int exp_first, input int limit, input string tag);
    int first = -1;
    bit err_seen = 0;
    @(negedge clk);
    reinit = 1'b1; lane_valid = '0; lane_bnd = '0;
    @(negedge clk);
    reinit = 1'b0;
    chk(!out_valid && !align_err, "R10", {out_valid, align_err}, 0);
    rel_offset = 8'(off); rel_now = imm[0];
    for (int i = 0; i <= limit; i++) begin
      if (i > 0) @(negedge clk);
      if (out_valid) begin
        if (first < 0) first = i;
        if (i - first < 4)
          for (int l = 0; l < LANES; l++)
            chk(out_data[l*DW +: DW] == {32'(l), 32'(i - first)}, (i == first) ? "R1" : "R6",
                out_data[l*DW +: DW], {32'(l), 32'(i - first)});
      end else if (first >= 0) chk(0, "R6", 0, 1);
      if (align_err) err_seen = 1;
      lmc_cnt = 5'(i % P);
      for (int l = 0; l < LANES; l++) begin
        automatic int st = (l == 0) ? s0 : s1;
        lane_valid[l] = (i >= st);
        lane_bnd[l]   = (i == st);
        lane_data[l*DW +: DW] = {32'(l), 32'(i - st)};
      end
    end
    if (exp_first < 0) begin
      chk(err_seen, tag, err_seen, 1);
      chk(first < 0, tag, first, -1);
    end else begin
      chk(first == exp_first, tag, first, exp_first);
      chk(rbd_count == 5'(exp_cnt), "R2", rbd_count, exp_cnt);
      chk(!err_seen, "R9", err_seen, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!out_valid && !align_err && rbd_count == 0, "R9", {out_valid, align_err, rbd_count}, 0);
    for (int v = 0; v < NV; v++)
      run_case(V_S0[v], V_S1[v], V_OFF[v], V_IMM[v], V_CNT[v], V_FST[v], 80,
               tag_of(V_OFF[v], V_IMM[v], V_FST[v]));
    // reset during output clears all status (R9, R2)
    chk(out_valid, "R6", out_valid, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!out_valid && !align_err && rbd_count == 0, "R9", {out_valid, align_err, rbd_count}, 0);
    // lane skew beyond buffer depth (R7)
    run_case(0, 1030, 0, 0, 0, -1, 1100, "R7");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule